// File: doc/BRIEF.md
# External Write-Buffer Hold-Off Gate

This block sits in the bus unit of a processor core. It decides when write-related work may go ahead. System logic drives an active-low flag (`bufempty_n_i`) that reports whether every external write buffer has drained. The gate looks at that flag only at two kinds of moment. The first is the ready strobe that closes an external write cycle, which for a four-transfer burst is the ready of the last transfer. The second is every clock after a failing look, until the flag is seen low. While the latest look shows the buffers still full, the gate raises `holding_o` and withholds grants from several requesters: the store buffer (for data-cache writes), the memory-write path (single, burst and locked accessed-bit updates), serializing instructions, and every interrupt class that writes memory.

Each requester keeps its request high until it sees a grant in a cycle. Grants are combinational from the requests and the hold state. Interrupt classes that never touch memory pass straight through. The store-buffer path and the memory-write path may both be waiting at once. In that case the gate grants one write per cycle, oldest request first, so the hold-off can never reorder writes. A system that ties the flag low sees no effect at all, and its write pace is set by the ready strobe alone.

Top module: `wbuf_holdoff_gate`

## Requirements
- R1: Synchronous active-high reset clears the hold-off state and any write cycle in progress, including a partial burst count. After reset, ready strobes without a new cycle start never set `holding_o`.
- R2: A single write cycle is sampled on its one ready. If `bufempty_n_i` is 1 there, `holding_o` is 1 in that same cycle, and store-buffer, memory-write and serializing grants are 0 in that cycle.
- R3: A burst cycle (`cyc_burst_i`=1 at `cyc_start_i`) is sampled only on its fourth ready. Readies one to three never set `holding_o`, whatever `bufempty_n_i` is.
- R4: Once held, `bufempty_n_i` is re-sampled on every clock. `holding_o` stays 1 through the cycle in which 0 is first seen, and it is 0 from the next cycle on.
- R5: Outside the closing ready of a write cycle, and while not holding, `bufempty_n_i` is ignored. `holding_o` stays 0.
- R6: While `holding_o`=1, `sb_gnt_o`, `mw_gnt_o` and `ser_gnt_o` are 0. While it is 0, a lone store-buffer request, a lone memory-write request and a serializing request are granted in the same cycle.
- R7: Interrupt class bits 3 (cache flush), 4 (system management) and 5 (memory-writing exception) are denied while holding. Bits 0 (reset), 1 (init) and 2 (stop clock) are always granted as requested.
- R8: With `bufempty_n_i` held at 0, single and burst writes never cause `holding_o` to be 1.
- R9: At most one of `sb_gnt_o` and `mw_gnt_o` is 1 in a cycle. If both are pending, the request that was raised earlier is granted first. If both are raised in the same cycle, the store-buffer request goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start_i | input | 1 | An external write cycle begins this clock |
| cyc_burst_i | input | 1 | With `cyc_start_i`: 1 = four-transfer burst, 0 = single |
| rdy_i | input | 1 | Bus ready strobe, one per transfer |
| bufempty_n_i | input | 1 | External write buffers empty, active low |
| sb_req_i | input | 1 | Store buffer asks to write the data cache |
| mw_req_i | input | 1 | Memory write request (single, burst or locked) |
| ser_req_i | input | 1 | Serializing instruction asks to execute |
| irq_req_i | input | 6 | Interrupt class requests, bit map as in R7 |
| sb_gnt_o | output | 1 | Store-buffer write granted |
| mw_gnt_o | output | 1 | Memory write granted |
| ser_gnt_o | output | 1 | Serializing instruction granted |
| irq_gnt_o | output | 6 | Interrupt class grants |
| holding_o | output | 1 | Hold-off in force this cycle |

## Verification
Some properties are checked by the assertions on every cycle. No write, serializing or memory-writing interrupt grant appears while holding. The non-writing interrupt classes always mirror their requests. The two write grants are never both high. A failing sample raises the hold at once, and a hold with the flag seen low ends one clock later. The bench scenarios are needed for the rest: the burst counting that ignores the first three readies, the clearing of a partial burst by reset, the oldest-first order of two waiting writes, and the absence of any hold when the flag is tied low.

// File: rtl/wbh_pkg.sv
package wbh_pkg;

  localparam int unsigned IDX_W = 8;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_BURST  = 1'b1
  } xfer_kind_e;

  // True when this ready closes the cycle: a single's only beat or a burst's last one.
  function automatic logic is_final_beat(input xfer_kind_e kind,
                                         input logic [IDX_W-1:0] idx,
                                         input int unsigned beats);
    return (kind == XFER_SINGLE) || (idx == IDX_W'(beats - 1));
  endfunction

  // Next hold state: a sample is taken on a closing ready or while already held;
  // the sampled (active-low) flag decides.
  function automatic logic next_hold(input logic held,
                                     input logic final_beat,
                                     input logic full_n);
    return (held | final_beat) & full_n;
  endfunction

  // Write arbitration between store buffer and memory path; returns {mw, sb}.
  function automatic logic [1:0] write_pick(input logic sb, input logic mw,
                                            input logic mw_older);
    return {mw & (~sb | mw_older), sb & (~mw | ~mw_older)};
  endfunction

  // Age tracking: a lone request marks its owner older; idle resets to store-buffer-first.
  function automatic logic next_mw_older(input logic sb, input logic mw,
                                         input logic cur);
    if (mw && !sb)       return 1'b1;
    else if (sb && !mw)  return 1'b0;
    else if (!sb && !mw) return 1'b0;
    else                 return cur;
  endfunction

endpackage

// File: rtl/wbh_cycle_tracker.sv
module wbh_cycle_tracker
  import wbh_pkg::*;
#(
  parameter int unsigned BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic burst_i,
  input  logic rdy_i,
  output logic final_beat_o
);

  localparam int unsigned CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             active_q;
  xfer_kind_e       kind_q;
  logic [CNT_W-1:0] beat_q;
  logic             closing;

  assign closing      = active_q & rdy_i & is_final_beat(kind_q, IDX_W'(beat_q), BEATS);
  assign final_beat_o = closing;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      kind_q   <= XFER_SINGLE;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      kind_q   <= burst_i ? XFER_BURST : XFER_SINGLE;
      beat_q   <= '0;
    end else if (active_q && rdy_i) begin
      if (closing) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q   <= beat_q + CNT_ONE;
      end
    end
  end

endmodule

// File: rtl/wbh_hold_ctrl.sv
module wbh_hold_ctrl
  import wbh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic final_beat_i,
  input  logic full_n_i,
  output logic hold_o
);

  logic held_q;

  // A failing sample holds in its own cycle; a held state persists until the flag is seen low.
  assign hold_o = held_q | (final_beat_i & full_n_i);

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= next_hold(held_q, final_beat_i, full_n_i);
  end

endmodule

// File: rtl/wbh_grant_gate.sv
module wbh_grant_gate
  import wbh_pkg::*;
#(
  parameter int unsigned           IRQ_CLASSES    = 6,
  parameter logic [IRQ_CLASSES-1:0] IRQ_WRITES_MEM = 6'b111000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hold_i,
  input  logic                   sb_req_i,
  input  logic                   mw_req_i,
  input  logic                   ser_req_i,
  input  logic [IRQ_CLASSES-1:0] irq_req_i,
  output logic                   sb_gnt_o,
  output logic                   mw_gnt_o,
  output logic                   ser_gnt_o,
  output logic [IRQ_CLASSES-1:0] irq_gnt_o
);

  logic       mw_older_q;
  logic [1:0] pick;

  assign pick      = write_pick(sb_req_i, mw_req_i, mw_older_q);
  assign sb_gnt_o  = pick[0] & ~hold_i;
  assign mw_gnt_o  = pick[1] & ~hold_i;
  assign ser_gnt_o = ser_req_i & ~hold_i;

  for (genvar c = 0; c < IRQ_CLASSES; c++) begin : g_irq
    if (IRQ_WRITES_MEM[c]) begin : g_gated
      assign irq_gnt_o[c] = irq_req_i[c] & ~hold_i;
    end else begin : g_free
      assign irq_gnt_o[c] = irq_req_i[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mw_older_q <= 1'b0;
    else     mw_older_q <= next_mw_older(sb_req_i, mw_req_i, mw_older_q);
  end

endmodule

// File: rtl/wbuf_holdoff_gate.sv
module wbuf_holdoff_gate
  import wbh_pkg::*;
#(
  parameter int unsigned            BEATS          = 4,
  parameter int unsigned            IRQ_CLASSES    = 6,
  parameter logic [IRQ_CLASSES-1:0] IRQ_WRITES_MEM = 6'b111000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cyc_start_i,
  input  logic                   cyc_burst_i,
  input  logic                   rdy_i,
  input  logic                   bufempty_n_i,
  input  logic                   sb_req_i,
  input  logic                   mw_req_i,
  input  logic                   ser_req_i,
  input  logic [IRQ_CLASSES-1:0] irq_req_i,
  output logic                   sb_gnt_o,
  output logic                   mw_gnt_o,
  output logic                   ser_gnt_o,
  output logic [IRQ_CLASSES-1:0] irq_gnt_o,
  output logic                   holding_o
);

  logic final_beat;
  logic hold;

  wbh_cycle_tracker #(.BEATS(BEATS)) u_track (
    .clk          (clk),
    .rst          (rst),
    .start_i      (cyc_start_i),
    .burst_i      (cyc_burst_i),
    .rdy_i        (rdy_i),
    .final_beat_o (final_beat)
  );

  wbh_hold_ctrl u_hold (
    .clk          (clk),
    .rst          (rst),
    .final_beat_i (final_beat),
    .full_n_i     (bufempty_n_i),
    .hold_o       (hold)
  );

  wbh_grant_gate #(
    .IRQ_CLASSES    (IRQ_CLASSES),
    .IRQ_WRITES_MEM (IRQ_WRITES_MEM)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (hold),
    .sb_req_i  (sb_req_i),
    .mw_req_i  (mw_req_i),
    .ser_req_i (ser_req_i),
    .irq_req_i (irq_req_i),
    .sb_gnt_o  (sb_gnt_o),
    .mw_gnt_o  (mw_gnt_o),
    .ser_gnt_o (ser_gnt_o),
    .irq_gnt_o (irq_gnt_o)
  );

  assign holding_o = hold;

endmodule

// File: rtl/wbh_checker.sv
module wbh_checker #(
  parameter int unsigned            IRQ_CLASSES    = 6,
  parameter logic [IRQ_CLASSES-1:0] IRQ_WRITES_MEM = 6'b111000
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   full_n,
  input logic                   final_beat,
  input logic                   hold,
  input logic                   sb_req,
  input logic                   mw_req,
  input logic                   sb_gnt,
  input logic                   mw_gnt,
  input logic                   ser_gnt,
  input logic [IRQ_CLASSES-1:0] irq_req,
  input logic [IRQ_CLASSES-1:0] irq_gnt
);

  // R2
  fail_sets_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (final_beat && full_n) |-> hold);

  // R4
  clear_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !full_n) |=> (!hold || final_beat));

  // R5
  no_spurious_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !final_beat) |=> (!hold || final_beat));

  // R6
  hold_blocks_writes_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !(sb_gnt || mw_gnt || ser_gnt));

  // R6
  lone_sb_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && sb_req && !mw_req) |-> sb_gnt);

  // R7
  hold_blocks_mem_irq_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> ((irq_gnt & IRQ_WRITES_MEM) == '0));

  // R7
  free_irq_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_gnt ^ irq_req) & ~IRQ_WRITES_MEM) == '0);

  // R9
  one_write_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({sb_gnt, mw_gnt}) <= 1);

endmodule

bind wbuf_holdoff_gate wbh_checker #(
  .IRQ_CLASSES    (IRQ_CLASSES),
  .IRQ_WRITES_MEM (IRQ_WRITES_MEM)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .full_n     (bufempty_n_i),
  .final_beat (final_beat),
  .hold       (hold),
  .sb_req     (sb_req_i),
  .mw_req     (mw_req_i),
  .sb_gnt     (sb_gnt_o),
  .mw_gnt     (mw_gnt_o),
  .ser_gnt    (ser_gnt_o),
  .irq_req    (irq_req_i),
  .irq_gnt    (irq_gnt_o)
);

// File: tb/wbuf_holdoff_gate_tb.sv
`timescale 1ns/1ps
module wbuf_holdoff_gate_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_start = 1'b0, cyc_burst = 1'b0, rdy = 1'b0, full_n = 1'b0;
  logic       sb_req = 1'b0, mw_req = 1'b0, ser_req = 1'b0;
  logic [5:0] irq_req = '0;
  logic       sb_gnt, mw_gnt, ser_gnt, holding;
  logic [5:0] irq_gnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  wbuf_holdoff_gate u_dut (
    .clk(clk), .rst(rst), .cyc_start_i(cyc_start), .cyc_burst_i(cyc_burst),
    .rdy_i(rdy), .bufempty_n_i(full_n), .sb_req_i(sb_req), .mw_req_i(mw_req),
    .ser_req_i(ser_req), .irq_req_i(irq_req), .sb_gnt_o(sb_gnt), .mw_gnt_o(mw_gnt),
    .ser_gnt_o(ser_gnt), .irq_gnt_o(irq_gnt), .holding_o(holding)
  );

  typedef struct {
    string      tag;
    logic       h, sb, mw, ser;
    logic [5:0] irq;
  } exp_t;

  exp_t sb_q[$];

  // Driver side: queue the expected outputs of the current cycle, then advance.
  task automatic step(input string tag, input logic h, input logic sb,
                      input logic mw, input logic ser, input logic [5:0] irq);
    exp_t e;
    e.tag = tag; e.h = h; e.sb = sb; e.mw = mw; e.ser = ser; e.irq = irq;
    sb_q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    cyc_start = 0; cyc_burst = 0; rdy = 0;
    sb_req = 0; mw_req = 0; ser_req = 0; irq_req = '0;
  endtask

  // Monitor: compare mid-cycle, away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if ({holding, sb_gnt, mw_gnt, ser_gnt, irq_gnt} !== {e.h, e.sb, e.mw, e.ser, e.irq}) begin
        n_fail++;
        $display("FAIL %s: actual hold=%b sb=%b mw=%b ser=%b irq=%b expected hold=%b sb=%b mw=%b ser=%b irq=%b",
                 e.tag, holding, sb_gnt, mw_gnt, ser_gnt, irq_gnt,
                 e.h, e.sb, e.mw, e.ser, e.irq);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    full_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    step("R1 reset state", 0, 0, 0, 0, '0);
    rst = 0;
    step("R1 after release", 0, 0, 0, 0, '0);

    // R1: a partial burst is dropped by reset
    full_n = 0; cyc_start = 1; cyc_burst = 1; step("R1 burst start", 0, 0, 0, 0, '0);
    cyc_start = 0; cyc_burst = 0;
    rdy = 1; step("R1 beat1", 0, 0, 0, 0, '0);
    step("R1 beat2", 0, 0, 0, 0, '0);
    rdy = 0; rst = 1; step("R1 reset mid-burst", 0, 0, 0, 0, '0);
    rst = 0; full_n = 1; rdy = 1;
    for (int i = 0; i < 4; i++) step("R1 stray ready after reset", 0, 0, 0, 0, '0);
    rdy = 0;

    // R2, R4, R5, R6: single write closing with buffers full
    sb_req = 1; step("R5 flag ignored while idle", 0, 1, 0, 0, '0);
    sb_req = 0; cyc_start = 1; step("R2 single start", 0, 0, 0, 0, '0);
    cyc_start = 0; ser_req = 1; step("R6 ser granted mid-cycle", 0, 0, 0, 1, '0);
    rdy = 1; sb_req = 1; step("R2 closing ready holds", 1, 0, 0, 0, '0);
    rdy = 0; step("R4 still held, flag high", 1, 0, 0, 0, '0);
    irq_req = 6'b111111; step("R7 mem irqs blocked", 1, 0, 0, 0, 6'b000111);
    irq_req = '0; full_n = 0; step("R4 held in the cycle flag seen low", 1, 0, 0, 0, '0);
    step("R4 released next cycle", 0, 1, 0, 1, '0);
    sb_req = 0; ser_req = 0; full_n = 1;
    irq_req = 6'b111111; step("R7 all irqs pass when free", 0, 0, 0, 0, 6'b111111);
    irq_req = '0; step("R5 flag high but no sample", 0, 0, 0, 0, '0);

    // R3: burst sampled only on the fourth ready
    cyc_start = 1; cyc_burst = 1; step("R3 burst start", 0, 0, 0, 0, '0);
    cyc_start = 0; cyc_burst = 0; rdy = 1;
    mw_req = 1; step("R3 beat1 ignored", 0, 0, 1, 0, '0);
    mw_req = 0; step("R3 beat2 ignored", 0, 0, 0, 0, '0);
    step("R3 beat3 ignored", 0, 0, 0, 0, '0);
    mw_req = 1; step("R3 beat4 samples", 1, 0, 0, 0, '0);
    rdy = 0; full_n = 0; step("R4 seen low", 1, 0, 0, 0, '0);
    step("R4 burst hold released", 0, 0, 1, 0, '0);
    mw_req = 0;

    // R8: flag tied low, single and burst writes never hold
    cyc_start = 1; step("R8 single start", 0, 0, 0, 0, '0);
    cyc_start = 0; rdy = 1; sb_req = 1; step("R8 single close", 0, 1, 0, 0, '0);
    rdy = 0; sb_req = 0; cyc_start = 1; cyc_burst = 1; step("R8 burst start", 0, 0, 0, 0, '0);
    cyc_start = 0; cyc_burst = 0; rdy = 1;
    for (int i = 0; i < 4; i++) step("R8 burst beat", 0, 0, 0, 0, '0);
    rdy = 0;

    // R9: older write first after a hold
    full_n = 1; cyc_start = 1; step("R9 single start", 0, 0, 0, 0, '0);
    cyc_start = 0; rdy = 1; step("R9 close full", 1, 0, 0, 0, '0);
    rdy = 0; mw_req = 1; step("R9 mw waits", 1, 0, 0, 0, '0);
    sb_req = 1; full_n = 0; step("R9 sb waits behind mw", 1, 0, 0, 0, '0);
    step("R9 older mw first", 0, 0, 1, 0, '0);
    mw_req = 0; step("R9 then sb", 0, 1, 0, 0, '0);
    sb_req = 0; step("R9 idle", 0, 0, 0, 0, '0);
    sb_req = 1; mw_req = 1; step("R9 simultaneous sb first", 0, 1, 0, 0, '0);
    sb_req = 0; step("R9 then mw", 0, 0, 1, 0, '0);
    idle_inputs(); step("R9 quiet", 0, 0, 0, 0, '0);

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule